// File: doc/BRIEF.md
# PCIe Advisory Error Classifier

This block sits beside the receive and request paths of a PCI Express endpoint and turns three kinds of error event into error-message requests toward the root complex. The events are a completion that arrived poisoned, a memory write that arrived poisoned, and a timed-out outbound non-posted request. Each event is graded as correctable, non-fatal or fatal. The grade depends on a per-type advisory enable held in a small control register and on a per-type severity input. A type marked fatal is never treated as advisory. An advisory event is reported as correctable. Any other event is reported as non-fatal.

The first error is captured into a log of header and descriptor or tag. The log raises an interrupt to the local processor and holds until software clears it. Firmware that has given up retrying an advisory error writes an escalation bit in the control register. That write produces exactly one non-fatal request. Message requests wait on a valid/ready handshake toward the message generator, and classes that are pending at the same time are served by severity. In a separate path, payload data is forwarded with a parity bit, and that parity bit is deliberately wrong when the data is poisoned.

Top module: `pcie_adv_err_classifier`

## Requirements
- R1: An event whose `sev_fatal` bit is 1 leads to a fatal request (`msg_type` 2), whatever its advisory enable. The bits of `sev_fatal` are ordered as 0 for poisoned completion, 1 for poisoned write and 2 for completion timeout.
- R2: An event that is not fatal and whose advisory enable is 1 leads to a correctable request (`msg_type` 0). The advisory enables sit at control bit 4 for poisoned completion, bit 5 for poisoned write and bit 6 for timeout.
- R3: An event that is neither fatal nor advisory leads to a non-fatal request (`msg_type` 1).
- R4: A control write with bit 0 set leads to one non-fatal request. Bit 0 reads back as 1 until that request is accepted, and as 0 in the cycle after acceptance.
- R5: `msg_valid` stays high until `msg_ready` is sampled high. Classes pending at the same time are served fatal first, then non-fatal, then correctable. Events of a class that is already pending merge into that class's single request.
- R6: A capture records the event kind in `log_kind` (0 for poisoned completion, 1 for poisoned write, 2 for timeout). For a completion it records header and descriptor. For a write it records the header and a zero descriptor. For a timeout it records the request header and the tag, zero-extended. When several events arrive together, the lowest kind code is logged.
- R7: The log keeps its first capture and ignores later events while `log_vld` is 1. `log_clr` clears it. An event in the same cycle as `log_clr` is captured.
- R8: `irq` equals `log_vld` at all times.
- R9: `out_data` and `out_vld` follow `in_data` and `in_vld` one cycle later. `out_par` is the XOR of the data bits, inverted when `in_poison` was set.
- R10: After reset there is no request, the log is empty, `irq` is low and the control readback is 0.
- R11: Control write bits other than 0 and 4 to 6 are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_cpl_poison | input | 1 | Poisoned completion seen (pulse) |
| evt_wr_poison | input | 1 | Poisoned memory write seen (pulse) |
| evt_cpl_timeout | input | 1 | Completion timeout of an outbound request (pulse) |
| cpl_hdr | input | HDR_W | Header of the poisoned completion |
| cpl_desc | input | DESC_W | DMA descriptor of the poisoned completion |
| wr_hdr | input | HDR_W | Header of the poisoned write |
| to_hdr | input | HDR_W | Header of the timed-out request |
| to_tag | input | TAG_W | Descriptor tag of the timed-out request |
| sev_fatal | input | 3 | Per-type fatal severity |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write data |
| cfg_rdata | output | CFG_W | Control register readback |
| log_clr | input | 1 | Clear the log valid bit (write-one-to-clear) |
| log_vld | output | 1 | Log holds a capture |
| log_kind | output | 2 | Kind of the logged event |
| log_hdr | output | HDR_W | Logged header |
| log_desc | output | DESC_W | Logged descriptor or tag |
| irq | output | 1 | Interrupt to the local processor |
| msg_valid | output | 1 | Error message request valid |
| msg_type | output | 2 | 0 correctable, 1 non-fatal, 2 fatal |
| msg_ready | input | 1 | Message generator accepts the request |
| in_vld | input | 1 | Payload beat valid |
| in_data | input | DATA_W | Payload beat |
| in_poison | input | 1 | Payload beat belongs to a poisoned packet |
| out_vld | output | 1 | Forwarded beat valid |
| out_data | output | DATA_W | Forwarded beat |
| out_par | output | 1 | Parity of the forwarded beat, bad when poisoned |

## Verification
Two functions can fall in the same cycle. A new event can arrive in the very cycle that its class's pending request is accepted, and an event capture can meet a log clear. The bench makes these collisions likely by driving the event strobes, `msg_ready` and `log_clr` at random every cycle. It also forces both collisions in a directed prologue. Every sampled output is compared with a cycle model in the bench. In that model a new request survives the acceptance of the old one, and a capture takes effect after a clear in the same cycle.

// File: rtl/aec_pkg.sv
package aec_pkg;
  typedef enum logic [1:0] {
    MSG_COR      = 2'd0,
    MSG_NONFATAL = 2'd1,
    MSG_FATAL    = 2'd2
  } msg_class_e;

  localparam int NUM_KINDS = 3;
  localparam int KIND_W    = 2;
  localparam logic [KIND_W-1:0] KIND_CPL = 2'd0;
  localparam logic [KIND_W-1:0] KIND_WR  = 2'd1;
  localparam logic [KIND_W-1:0] KIND_TO  = 2'd2;

  function automatic msg_class_e grade(input logic adv_en, input logic is_fatal);
    if (is_fatal)    return MSG_FATAL;
    else if (adv_en) return MSG_COR;
    else             return MSG_NONFATAL;
  endfunction
endpackage

// File: rtl/aec_classify.sv
module aec_classify
  import aec_pkg::*;
#(
  parameter int N = NUM_KINDS
) (
  input  logic [N-1:0] evt,
  input  logic [N-1:0] adv_en,
  input  logic [N-1:0] sev_fatal,
  output logic         set_f,
  output logic         set_n,
  output logic         set_c
);
  logic [N-1:0] hit_f, hit_n, hit_c;

  for (genvar g = 0; g < N; g++) begin : g_kind
    msg_class_e cls;
    always_comb begin
      cls      = grade(adv_en[g], sev_fatal[g]);
      hit_f[g] = evt[g] && (cls == MSG_FATAL);
      hit_n[g] = evt[g] && (cls == MSG_NONFATAL);
      hit_c[g] = evt[g] && (cls == MSG_COR);
    end
  end

  assign set_f = |hit_f;
  assign set_n = |hit_n;
  assign set_c = |hit_c;
endmodule

// File: rtl/aec_msg_arb.sv
module aec_msg_arb
  import aec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_f,
  input  logic       set_n,
  input  logic       set_c,
  input  logic       gen_req,
  input  logic       msg_ready,
  output logic       msg_valid,
  output logic [1:0] msg_type,
  output logic       nf_accept
);
  logic pend_f_q, pend_n_q, pend_c_q;
  logic pend_f_d, pend_n_d, pend_c_d;
  logic take;
  msg_class_e head;

  always_comb begin
    if (pend_f_q)                 head = MSG_FATAL;
    else if (pend_n_q || gen_req) head = MSG_NONFATAL;
    else                          head = MSG_COR;
  end

  assign msg_valid = pend_f_q || pend_n_q || pend_c_q || gen_req;
  assign msg_type  = head;
  assign take      = msg_valid && msg_ready;
  assign nf_accept = take && (head == MSG_NONFATAL);

  always_comb begin
    pend_f_d = (pend_f_q && !(take && head == MSG_FATAL)) || set_f;
    pend_n_d = (pend_n_q && !nf_accept) || set_n;
    pend_c_d = (pend_c_q && !(take && head == MSG_COR)) || set_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_f_q <= 1'b0;
      pend_n_q <= 1'b0;
      pend_c_q <= 1'b0;
    end else begin
      pend_f_q <= pend_f_d;
      pend_n_q <= pend_n_d;
      pend_c_q <= pend_c_d;
    end
  end

  a_r5_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);
endmodule

// File: rtl/aec_err_log.sv
module aec_err_log
  import aec_pkg::*;
#(
  parameter int HDR_W  = 32,
  parameter int DESC_W = 16,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        evt,
  input  logic [HDR_W-1:0]  cpl_hdr,
  input  logic [DESC_W-1:0] cpl_desc,
  input  logic [HDR_W-1:0]  wr_hdr,
  input  logic [HDR_W-1:0]  to_hdr,
  input  logic [TAG_W-1:0]  to_tag,
  input  logic              log_clr,
  output logic              log_vld,
  output logic [KIND_W-1:0] log_kind,
  output logic [HDR_W-1:0]  log_hdr,
  output logic [DESC_W-1:0] log_desc
);
  logic              vld_q, vld_d, cap_en;
  logic [KIND_W-1:0] kind_q, kind_d;
  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [DESC_W-1:0] desc_q, desc_d;

  always_comb begin
    kind_d = KIND_TO;
    hdr_d  = to_hdr;
    desc_d = DESC_W'(to_tag);
    if (evt[0]) begin
      kind_d = KIND_CPL;
      hdr_d  = cpl_hdr;
      desc_d = cpl_desc;
    end else if (evt[1]) begin
      kind_d = KIND_WR;
      hdr_d  = wr_hdr;
      desc_d = '0;
    end
    cap_en = (|evt) && (!vld_q || log_clr);
    vld_d  = cap_en || (vld_q && !log_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      hdr_q  <= '0;
      desc_q <= '0;
    end else if (cap_en) begin
      kind_q <= kind_d;
      hdr_q  <= hdr_d;
      desc_q <= desc_d;
    end
  end

  assign log_vld  = vld_q;
  assign log_kind = kind_q;
  assign log_hdr  = hdr_q;
  assign log_desc = desc_q;

  a_r7_log_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (log_vld && !log_clr) |=> (log_vld && $stable(log_hdr) && $stable(log_kind)));
endmodule

// File: rtl/aec_par_fwd.sv
module aec_par_fwd #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_poison,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par
);
  logic par_d;

  always_comb par_d = (^in_data) ^ in_poison;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_par  <= 1'b0;
    end else if (in_vld) begin
      out_data <= in_data;
      out_par  <= par_d;
    end
  end

  a_r9_bad_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((out_par ^ (^out_data)) == $past(in_poison)));
endmodule

// File: rtl/pcie_adv_err_classifier.sv
module pcie_adv_err_classifier
  import aec_pkg::*;
#(
  parameter int HDR_W  = 32,
  parameter int DESC_W = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_cpl_poison,
  input  logic              evt_wr_poison,
  input  logic              evt_cpl_timeout,
  input  logic [HDR_W-1:0]  cpl_hdr,
  input  logic [DESC_W-1:0] cpl_desc,
  input  logic [HDR_W-1:0]  wr_hdr,
  input  logic [HDR_W-1:0]  to_hdr,
  input  logic [TAG_W-1:0]  to_tag,
  input  logic [2:0]        sev_fatal,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              log_clr,
  output logic              log_vld,
  output logic [1:0]        log_kind,
  output logic [HDR_W-1:0]  log_hdr,
  output logic [DESC_W-1:0] log_desc,
  output logic              irq,
  output logic              msg_valid,
  output logic [1:0]        msg_type,
  input  logic              msg_ready,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_poison,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par
);
  localparam int GEN_BIT = 0;
  localparam int ADV_LSB = 4;

  logic [NUM_KINDS-1:0] evt, adv_q, adv_d;
  logic gen_q, gen_d, gen_wr;
  logic set_f, set_n, set_c, nf_accept;

  assign evt    = {evt_cpl_timeout, evt_wr_poison, evt_cpl_poison};
  assign gen_wr = cfg_we && cfg_wdata[GEN_BIT];

  always_comb begin
    adv_d = cfg_we ? cfg_wdata[ADV_LSB +: NUM_KINDS] : adv_q;
    gen_d = (gen_q && !nf_accept) || gen_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q <= '0;
      gen_q <= 1'b0;
    end else begin
      adv_q <= adv_d;
      gen_q <= gen_d;
    end
  end

  always_comb begin
    cfg_rdata                        = '0;
    cfg_rdata[GEN_BIT]               = gen_q;
    cfg_rdata[ADV_LSB +: NUM_KINDS]  = adv_q;
  end

  aec_classify #(.N(NUM_KINDS)) u_classify (
    .evt(evt), .adv_en(adv_q), .sev_fatal(sev_fatal),
    .set_f(set_f), .set_n(set_n), .set_c(set_c)
  );

  aec_msg_arb u_arb (
    .clk(clk), .rst_n(rst_n), .set_f(set_f), .set_n(set_n), .set_c(set_c),
    .gen_req(gen_q), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_type(msg_type), .nf_accept(nf_accept)
  );

  aec_err_log #(.HDR_W(HDR_W), .DESC_W(DESC_W), .TAG_W(TAG_W)) u_log (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cpl_hdr(cpl_hdr), .cpl_desc(cpl_desc),
    .wr_hdr(wr_hdr), .to_hdr(to_hdr), .to_tag(to_tag), .log_clr(log_clr),
    .log_vld(log_vld), .log_kind(log_kind), .log_hdr(log_hdr), .log_desc(log_desc)
  );

  assign irq = log_vld;

  aec_par_fwd #(.DATA_W(DATA_W)) u_par (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .in_poison(in_poison), .out_vld(out_vld), .out_data(out_data), .out_par(out_par)
  );

  a_r1_fatal_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & sev_fatal)) |=> (msg_valid && msg_type == MSG_FATAL));

  a_r4_gen_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && msg_valid && msg_ready && msg_type == MSG_NONFATAL && !gen_wr) |=> !cfg_rdata[GEN_BIT]);

  a_r8_irq_follows_log: assert property (@(posedge clk) disable iff (!rst_n)
    (log_vld && !log_clr) |=> irq);
endmodule

// File: tb/test_pcie_adv_err_classifier.sv
`timescale 1ns/1ps
module test_pcie_adv_err_classifier;
  localparam int HDR_W = 32, DESC_W = 16, TAG_W = 8, DATA_W = 32, CFG_W = 8;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n;
  logic e_cpl, e_wr, e_to;
  logic [HDR_W-1:0] cpl_hdr, wr_hdr, to_hdr;
  logic [DESC_W-1:0] cpl_desc;
  logic [TAG_W-1:0] to_tag;
  logic [2:0] sev_fatal;
  logic cfg_we, log_clr, msg_ready, in_vld, in_poison;
  logic [CFG_W-1:0] cfg_wdata, cfg_rdata;
  logic [DATA_W-1:0] in_data, out_data;
  logic log_vld, irq, msg_valid, out_vld, out_par;
  logic [1:0] log_kind, msg_type;
  logic [HDR_W-1:0] log_hdr;
  logic [DESC_W-1:0] log_desc;

  int tests = 0, fails = 0;

  // model state
  logic m_pf, m_pn, m_pc, m_gen, m_lv, m_ov, m_op;
  logic [2:0] m_adv;
  logic [1:0] m_kind;
  logic [HDR_W-1:0] m_hdr;
  logic [DESC_W-1:0] m_desc;
  logic [DATA_W-1:0] m_od;

  always #2 clk = ~clk;

  pcie_adv_err_classifier #(.HDR_W(HDR_W), .DESC_W(DESC_W), .TAG_W(TAG_W),
    .DATA_W(DATA_W), .CFG_W(CFG_W)) i_pcie_adv_err_classifier (
    .clk(clk), .rst_n(rst_n), .evt_cpl_poison(e_cpl), .evt_wr_poison(e_wr),
    .evt_cpl_timeout(e_to), .cpl_hdr(cpl_hdr), .cpl_desc(cpl_desc), .wr_hdr(wr_hdr),
    .to_hdr(to_hdr), .to_tag(to_tag), .sev_fatal(sev_fatal), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .log_clr(log_clr), .log_vld(log_vld),
    .log_kind(log_kind), .log_hdr(log_hdr), .log_desc(log_desc), .irq(irq),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_ready(msg_ready),
    .in_vld(in_vld), .in_data(in_data), .in_poison(in_poison), .out_vld(out_vld),
    .out_data(out_data), .out_par(out_par));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] m_head();
    if (m_pf) return 2'd2;
    else if (m_pn || m_gen) return 2'd1;
    else return 2'd0;
  endfunction

  task automatic compare();
    logic mv;
    mv = m_pf || m_pn || m_pc || m_gen;
    chk("R5 R10 msg_valid", 64'(msg_valid), 64'(mv));
    if (mv) chk("R1 R2 R3 R5 msg_type", 64'(msg_type), 64'(m_head()));
    chk("R4 R10 R11 cfg_rdata", 64'(cfg_rdata), 64'({1'b0, m_adv, 3'b000, m_gen}));
    chk("R7 R10 log_vld", 64'(log_vld), 64'(m_lv));
    chk("R8 irq", 64'(irq), 64'(m_lv));
    if (m_lv) begin
      chk("R6 log_kind", 64'(log_kind), 64'(m_kind));
      chk("R6 R7 log_hdr", 64'(log_hdr), 64'(m_hdr));
      chk("R6 log_desc", 64'(log_desc), 64'(m_desc));
    end
    chk("R9 out_vld", 64'(out_vld), 64'(m_ov));
    if (m_ov) begin
      chk("R9 out_data", 64'(out_data), 64'(m_od));
      chk("R9 out_par", 64'(out_par), 64'(m_op));
    end
  endtask

  task automatic model_step();
    logic [2:0] ev;
    logic sf, sn, sc, take, acc_f, acc_n, acc_c, mv;
    logic [1:0] hd;
    ev = {e_to, e_wr, e_cpl};
    sf = 0; sn = 0; sc = 0;
    for (int i = 0; i < 3; i++) if (ev[i]) begin
      if (sev_fatal[i]) sf = 1;
      else if (m_adv[i]) sc = 1;
      else sn = 1;
    end
    mv = m_pf || m_pn || m_pc || m_gen;
    hd = m_head();
    take = mv && msg_ready;
    acc_f = take && hd == 2'd2;
    acc_n = take && hd == 2'd1;
    acc_c = take && hd == 2'd0;
    m_pf = (m_pf && !acc_f) || sf;
    m_pn = (m_pn && !acc_n) || sn;
    m_pc = (m_pc && !acc_c) || sc;
    m_gen = (m_gen && !acc_n) || (cfg_we && cfg_wdata[0]);
    if (cfg_we) m_adv = cfg_wdata[6:4];
    if (log_clr) m_lv = 0;
    if (!m_lv && ev != 0) begin
      m_lv = 1;
      if (ev[0]) begin m_kind = 0; m_hdr = cpl_hdr; m_desc = cpl_desc; end
      else if (ev[1]) begin m_kind = 1; m_hdr = wr_hdr; m_desc = '0; end
      else begin m_kind = 2; m_hdr = to_hdr; m_desc = DESC_W'(to_tag); end
    end
    m_ov = in_vld;
    if (in_vld) begin m_od = in_data; m_op = (^in_data) ^ in_poison; end
  endtask

  task automatic idle_inputs();
    {e_cpl, e_wr, e_to} = 3'b000;
    sev_fatal = 3'b000; cfg_we = 0; cfg_wdata = '0; log_clr = 0;
    msg_ready = 0; in_vld = 0; in_poison = 0;
    cpl_hdr = $urandom; wr_hdr = $urandom; to_hdr = $urandom;
    cpl_desc = DESC_W'($urandom); to_tag = TAG_W'($urandom); in_data = $urandom;
  endtask

  task automatic rand_inputs();
    idle_inputs();
    e_cpl = ($urandom_range(0, 4) == 0);
    e_wr  = ($urandom_range(0, 4) == 0);
    e_to  = ($urandom_range(0, 4) == 0);
    for (int i = 0; i < 3; i++) sev_fatal[i] = ($urandom_range(0, 3) == 0);
    cfg_we = ($urandom_range(0, 11) == 0);
    cfg_wdata = CFG_W'($urandom);
    log_clr = ($urandom_range(0, 9) == 0);
    msg_ready = $urandom_range(0, 1) == 1;
    in_vld = $urandom_range(0, 1) == 1;
    in_poison = ($urandom_range(0, 2) == 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    rst_n = 0;
    idle_inputs();
    {m_pf, m_pn, m_pc, m_gen, m_lv, m_ov, m_op} = '0;
    m_adv = '0; m_kind = '0; m_hdr = '0; m_desc = '0; m_od = '0;
    repeat (3) @(negedge clk);
    compare();  // R10 reset state
    rst_n = 1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      compare();
      idle_inputs();
      case (cyc)
        0: begin cfg_we = 1; cfg_wdata = 8'hAE; end            // R2 advisory on write kind, R11 junk bits
        1: begin {e_to, e_wr, e_cpl} = 3'b111; sev_fatal = 3'b001; end // R1 R2 R3 R5 all classes at once
        2: ;                                                    // R5 hold without ready
        3, 4, 5: msg_ready = 1;                                 // R5 order fatal, non-fatal, correctable
        6: begin cfg_we = 1; cfg_wdata = 8'h21; end             // R4 escalation
        7: ;
        8: msg_ready = 1;                                       // R4 accept
        9: ;                                                    // R4 bit reads 0
        10: e_to = 1;                                           // R7 ignored, log still full
        11: begin log_clr = 1; e_wr = 1; end                    // R7 clear and capture together
        12: begin log_clr = 1; in_vld = 1; in_poison = 1; end   // R9 poisoned beat
        13: begin e_to = 1; in_vld = 1; msg_ready = 1; end      // R6 timeout tag, R9 clean beat
        14, 15, 16, 17: msg_ready = 1;
        default: if (cyc >= 20) rand_inputs();
      endcase
      model_step();
    end
    @(negedge clk);
    compare();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule